// File: doc/BRIEF.md
# Read Strobe Postamble Gating Unit

This unit builds the enable that gates a bidirectional read strobe before it clocks the read-data capture registers. The strobe is passed through only while a read burst is in progress. When the burst ends, the gated strobe is held at zero. Any ringing or glitch on the strobe line while it sits low before going to high impedance therefore never reaches the data registers.

The controller raises an enable request for the length of each burst. The request is taken either through an optional half-rate capture register, for a controller that runs at half the I/O frequency, or directly, when bypass is set. The request then reaches a full-rate postamble register. A second register holds a copy of that value delayed by half a full-rate period. The enable is the AND of the two registers. As a result the enable rises half a period after the full-rate register, and it falls on the same edge as that register. This AND stage also stops a stale high state from a previous burst from opening the gate early when reads are not back-to-back.

The strobe is modelled as a sampled digital signal on `clk`. One `clk` period equals half a full-rate period. `fr_tick_i` marks the full-rate postamble clock edges and `hr_tick_i` marks the half-rate resynchronization clock edges.

Top module: `read_strobe_gate`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `dqs_en_o` is 0 and every bit of `dqs_gated_o` is 0.
- R2: In every cycle, each bit of `dqs_gated_o` equals the same bit of `dqs_i` ANDed with `dqs_en_o`. While the enable is 0, the gated strobe is 0 whatever the raw strobe does.
- R3: With `bypass_i`=0, `req_i` is captured by the half-rate register on a `clk` edge where `hr_tick_i`=1. The full-rate register takes the half-rate register's value on a `clk` edge where `fr_tick_i`=1.
- R4: With `bypass_i`=1, the full-rate register takes `req_i` directly on a `clk` edge where `fr_tick_i`=1. The half-rate register is not on the path.
- R5: The enable asserts with half-cycle latency. In the cycle where the full-rate register first shows 1, `dqs_en_o` is still 0. It becomes 1 HALF_TICKS `clk` cycles later (default 1) if the register is still high.
- R6: The enable deasserts with zero latency. `dqs_en_o` is 0 in the first cycle where the full-rate register shows 0.
- R7: `dqs_en_o` is 1 only when the full-rate register is 1 now and was also 1 HALF_TICKS cycles earlier. After a gap between bursts, the first cycle of a new burst therefore shows the enable low.
- R8: When bursts are back-to-back (`req_i` held high across the boundary), `dqs_en_o` stays 1 across the boundary with no low cycle.
- R9: The full-rate register, and so the enable, changes only on `clk` edges where `fr_tick_i`=1. A half-rate tick on its own does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, two per full-rate period |
| rst | input | 1 | Synchronous active-high reset |
| hr_tick_i | input | 1 | Marks a half-rate resynchronization clock edge |
| fr_tick_i | input | 1 | Marks a full-rate postamble clock edge |
| bypass_i | input | 1 | 1: request goes straight to the full-rate register |
| req_i | input | 1 | Postamble-enable request from the controller |
| dqs_i | input | STROBES | Sampled raw read strobe |
| dqs_gated_o | output | STROBES | Strobe gated by the enable |
| dqs_en_o | output | 1 | Registered gating enable |

## Verification
Latency is counted from the full-rate tick edge. A request taken on that edge is visible in the full-rate register right after it. The enable follows one `clk` edge later when rising and immediately when falling. In staged mode, one extra half-rate tick edge comes before all of this. The gated strobe is combinational from `dqs_i` and the enable, so it must match in the same cycle. The bench keeps a per-edge history of the modelled full-rate register. It compares both outputs at every falling edge, after the rising edge that produced them and before new inputs are driven.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    typedef enum logic {
        PATH_STAGED = 1'b0,
        PATH_DIRECT = 1'b1
    } req_path_e;

    typedef struct packed {
        logic now_q;
        logic late_q;
    } en_pair_t;

    function automatic logic pick_source(req_path_e path, logic raw_req, logic staged_req);
        return (path == PATH_DIRECT) ? raw_req : staged_req;
    endfunction

    function automatic logic pair_enable(en_pair_t p);
        return p.now_q & p.late_q;
    endfunction

endpackage

// File: rtl/rsg_req_stage.sv
module rsg_req_stage
    import rsg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hr_tick_i,
    input  logic bypass_i,
    input  logic req_i,
    output logic hr_q_o,
    output logic src_o
);
    logic      hr_q;
    req_path_e path;

    always_ff @(posedge clk) begin
        if (rst)
            hr_q <= 1'b0;
        else if (hr_tick_i)
            hr_q <= req_i;
    end

    always_comb begin
        path  = bypass_i ? PATH_DIRECT : PATH_STAGED;
        src_o = pick_source(path, req_i, hr_q);
    end

    assign hr_q_o = hr_q;
endmodule

// File: rtl/rsg_en_core.sv
module rsg_en_core
    import rsg_pkg::*;
#(
    parameter int HALF_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fr_tick_i,
    input  logic src_i,
    output logic fr_q_o,
    output logic en_o
);
    logic                  fr_q;
    logic [HALF_TICKS-1:0] dly_q;
    en_pair_t              pair;

    always_ff @(posedge clk) begin
        if (rst)
            fr_q <= 1'b0;
        else if (fr_tick_i)
            fr_q <= src_i;
    end

    for (genvar g = 0; g < HALF_TICKS; g++) begin : g_dly
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) dly_q[0] <= 1'b0;
                else     dly_q[0] <= fr_q;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) dly_q[g] <= 1'b0;
                else     dly_q[g] <= dly_q[g-1];
            end
        end
    end

    always_comb begin
        pair.now_q  = fr_q;
        pair.late_q = dly_q[HALF_TICKS-1];
        en_o        = pair_enable(pair);
    end

    assign fr_q_o = fr_q;
endmodule

// File: rtl/rsg_strobe_gate.sv
module rsg_strobe_gate #(
    parameter int STROBES = 1
) (
    input  logic [STROBES-1:0] dqs_i,
    input  logic               en_i,
    output logic [STROBES-1:0] gated_o
);
    for (genvar s = 0; s < STROBES; s++) begin : g_lane
        assign gated_o[s] = dqs_i[s] & en_i;
    end
endmodule

// File: rtl/read_strobe_gate.sv
module read_strobe_gate #(
    parameter int STROBES    = 1,
    parameter int HALF_TICKS = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hr_tick_i,
    input  logic               fr_tick_i,
    input  logic               bypass_i,
    input  logic               req_i,
    input  logic [STROBES-1:0] dqs_i,
    output logic [STROBES-1:0] dqs_gated_o,
    output logic               dqs_en_o
);
    logic hr_q;
    logic src;
    logic fr_q;

    rsg_req_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .hr_tick_i (hr_tick_i),
        .bypass_i  (bypass_i),
        .req_i     (req_i),
        .hr_q_o    (hr_q),
        .src_o     (src)
    );

    rsg_en_core #(.HALF_TICKS(HALF_TICKS)) u_core (
        .clk       (clk),
        .rst       (rst),
        .fr_tick_i (fr_tick_i),
        .src_i     (src),
        .fr_q_o    (fr_q),
        .en_o      (dqs_en_o)
    );

    rsg_strobe_gate #(.STROBES(STROBES)) u_gate (
        .dqs_i   (dqs_i),
        .en_i    (dqs_en_o),
        .gated_o (dqs_gated_o)
    );
endmodule

// File: rtl/read_strobe_gate_chk.sv
module read_strobe_gate_chk #(
    parameter int STROBES = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               fr_tick_i,
    input logic               bypass_i,
    input logic               req_i,
    input logic               hr_q,
    input logic               fr_q,
    input logic [STROBES-1:0] dqs_gated_o,
    input logic               dqs_en_o
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!dqs_en_o && dqs_gated_o == '0)); // R1
    AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst) !dqs_en_o |-> dqs_gated_o == '0); // R2
    AST_STAGED_PATH: assert property (@(posedge clk) disable iff (rst) (fr_tick_i && !bypass_i) |=> fr_q == $past(hr_q)); // R3
    AST_DIRECT_PATH: assert property (@(posedge clk) disable iff (rst) (fr_tick_i && bypass_i) |=> fr_q == $past(req_i)); // R4
    AST_RISE_LATE: assert property (@(posedge clk) disable iff (rst) $rose(fr_q) |-> !dqs_en_o); // R5
    AST_FALL_NOW: assert property (@(posedge clk) disable iff (rst) !fr_q |-> !dqs_en_o); // R6
    AST_NO_STALE_OPEN: assert property (@(posedge clk) disable iff (rst) dqs_en_o |-> $past(fr_q)); // R7
    AST_FR_HOLD: assert property (@(posedge clk) disable iff (rst) !fr_tick_i |=> $stable(fr_q)); // R9
endmodule

bind read_strobe_gate read_strobe_gate_chk #(.STROBES(STROBES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fr_tick_i   (fr_tick_i),
    .bypass_i    (bypass_i),
    .req_i       (req_i),
    .hr_q        (hr_q),
    .fr_q        (fr_q),
    .dqs_gated_o (dqs_gated_o),
    .dqs_en_o    (dqs_en_o)
);

// File: tb/read_strobe_gate_tb.sv
`timescale 1ns/1ps
module read_strobe_gate_tb;
    localparam int H = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hr_tick_i = 1'b0;
    logic fr_tick_i = 1'b0;
    logic bypass_i = 1'b0;
    logic req_i = 1'b0;
    logic [0:0] dqs_i = 1'b0;
    logic [0:0] dqs_gated_o;
    logic dqs_en_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;
    string tag = "R1";

    // model state
    bit m_hr = 0;
    bit m_fr = 0;
    bit hist[$];

    always #10 clk = ~clk;

    read_strobe_gate #(.STROBES(1), .HALF_TICKS(H)) u_dut (
        .clk(clk), .rst(rst), .hr_tick_i(hr_tick_i), .fr_tick_i(fr_tick_i),
        .bypass_i(bypass_i), .req_i(req_i), .dqs_i(dqs_i),
        .dqs_gated_o(dqs_gated_o), .dqs_en_o(dqs_en_o)
    );

    always @(posedge clk) begin
        bit nhr;
        bit nfr;
        if (rst) begin
            m_hr = 0;
            m_fr = 0;
            hist.delete();
            for (int i = 0; i <= H; i++) hist.push_back(1'b0);
        end else begin
            nhr = hr_tick_i ? req_i : m_hr;
            nfr = fr_tick_i ? (bypass_i ? req_i : m_hr) : m_fr;
            m_hr = nhr;
            m_fr = nfr;
            hist.push_front(m_fr);
            while (hist.size() > H + 1) void'(hist.pop_back());
        end
    end

    task automatic check_now();
        bit exp_en;
        bit exp_g;
        exp_en = (hist.size() > H) ? (hist[0] & hist[H]) : 1'b0;
        exp_g  = dqs_i[0] & exp_en;
        checks++;
        if (dqs_en_o !== exp_en) begin
            failures++;
            $display("FAIL %s dqs_en_o actual=%0b expected=%0b cycle=%0d", tag, dqs_en_o, exp_en, cyc);
        end
        checks++;
        if (dqs_gated_o[0] !== exp_g) begin
            failures++;
            $display("FAIL %s dqs_gated_o actual=%0b expected=%0b cycle=%0d", tag, dqs_gated_o[0], exp_g, cyc);
        end
    endtask

    // one cycle: compare, then drive next inputs
    task automatic step(bit req, bit byp, bit toggle);
        @(negedge clk);
        check_now();
        cyc++;
        req_i     = req;
        bypass_i  = byp;
        dqs_i[0]  = toggle ? ~dqs_i[0] : 1'b0;
        fr_tick_i = (cyc % 2) == 0;
        hr_tick_i = (cyc % 4) == 1;
    endtask

    task automatic run(string t, int n, bit req, bit byp, bit toggle);
        tag = t;
        for (int i = 0; i < n; i++) step(req, byp, toggle);
    endtask

    initial begin
        for (int i = 0; i <= H; i++) hist.push_back(1'b0);
        rst = 1'b1;
        run("R1", 4, 1, 1, 1);              // reset: request and strobe ignored
        @(negedge clk); rst = 1'b0;
        run("R1", 2, 0, 1, 1);
        // direct path, single burst: rise after half cycle, fall at once
        run("R4", 2, 0, 1, 1);
        run("R5", 6, 1, 1, 1);
        run("R6", 6, 0, 1, 1);
        // raw strobe toggles while enable low and high
        run("R2", 4, 0, 1, 1);
        run("R2", 5, 1, 1, 1);
        run("R2", 5, 0, 1, 1);
        // staged path through half-rate register
        run("R3", 10, 1, 0, 1);
        run("R3", 10, 0, 0, 1);
        // back-to-back bursts: request held across boundary
        run("R8", 8, 1, 1, 1);
        run("R8", 8, 1, 1, 1);
        run("R8", 4, 0, 1, 1);
        // non-consecutive bursts with short gaps
        for (int k = 0; k < 3; k++) begin
            run("R7", 3, 1, 1, 1);
            run("R7", 2, 0, 1, 1);
        end
        run("R7", 4, 0, 1, 0);
        // request changes between full-rate ticks only
        for (int k = 0; k < 6; k++) begin
            tag = "R9";
            step((k % 2) == 0, 1, 1);
        end
        run("R9", 12, 1, 0, 1);
        run("R9", 6, 0, 0, 1);
        // mode switch mid-stream
        run("R4", 5, 1, 0, 1);
        run("R4", 5, 1, 1, 1);
        run("R6", 6, 0, 1, 1);
        @(negedge clk);
        check_now();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at cycle=%0d", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule